// File: doc/BRIEF.md
# Nested-Loop Scan Pattern Generator

This block is the front stage of a two-dimensional address generator. It moves a sliding window across a data memory that is organised as a plane, producing one handle position (an x and a y coordinate, each 16 bits by default) per output transfer. The walk is described by up to four nested loops. Every loop level has its own start, signed increment and end value for each of the two dimensions. The emitted position is the sum of the current coordinates of all levels. A plain row-by-row sweep is one level stepping x and one level stepping y.

A one-cycle start pulse captures the whole parameter set and begins the walk. Positions leave over a valid/ready handshake, so a downstream offset stage can stall the walk at any point. Along with each position the block reports, for every level, whether that level is in its first or its last iteration. The next stage uses this to switch offset sequences, for example to fill or flush a pipeline. When the outermost loop has finished, a done flag is raised and held until the next start.

Top module: `scan_pattern_gen`

## Requirements
- R1: After reset, pos_valid and done are low and stay low until a start pulse is taken.
- R2: A start pulse while no walk is running (idle or done) captures all parameters. From the next cycle, pos_valid is high, every bit of pos_first is high, and the position is the sum of the start values.
- R3: pos_x and pos_y are the sums, modulo 2^16, of the current x and current y coordinates of all levels.
- R4: A level's coordinates are unsigned and its increments are two's complement. A dimension with a zero increment never ends its loop. A dimension with a non-zero increment ends the loop when its next value, computed without wrap-around, would be above the end value (positive increment) or below it (negative increment). A level ends when either dimension ends it. A level whose two increments are both zero runs exactly one iteration.
- R5: Level 0 is the innermost loop. On each accepted position, the lowest level that is not in its last iteration takes one step in both dimensions, and every lower level reloads its start values.
- R6: Bit i of pos_first is high exactly while level i is in its first iteration since its last load or reload.
- R7: Bit i of pos_last is high exactly while level i is in its final iteration according to R4.
- R8: While pos_valid is high and pos_ready is low, pos_valid stays high and pos_x, pos_y, pos_first and pos_last hold their values.
- R9: The cycle after a position is accepted with every bit of pos_last high, pos_valid falls and done rises. done then stays high until a new start pulse is taken, and that pulse restarts the walk.
- R10: A start pulse while a walk is running is ignored. Changes to the parameter inputs after the start pulse do not affect the running walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture parameters and begin a walk |
| cfg_x_start | input | LEVELS*COORD_W | Per-level x start, level i at bits [i*COORD_W +: COORD_W] |
| cfg_x_step | input | LEVELS*COORD_W | Per-level signed x increment |
| cfg_x_end | input | LEVELS*COORD_W | Per-level x end |
| cfg_y_start | input | LEVELS*COORD_W | Per-level y start |
| cfg_y_step | input | LEVELS*COORD_W | Per-level signed y increment |
| cfg_y_end | input | LEVELS*COORD_W | Per-level y end |
| pos_ready | input | 1 | Downstream accepts the current position |
| pos_valid | output | 1 | A handle position is presented |
| pos_x | output | COORD_W | Handle x coordinate |
| pos_y | output | COORD_W | Handle y coordinate |
| pos_first | output | LEVELS | Per-level first-iteration flags, bit 0 innermost |
| pos_last | output | LEVELS | Per-level last-iteration flags, bit 0 innermost |
| done | output | 1 | Outermost loop finished |

## Verification
The hardest situations to reach are a carry that ripples through several levels on one accepted position, combined with negative increments and end tests near the top of the 16-bit range. In that case the pass-the-end comparison must not wrap, and the summed position does wrap. The stimulus builds parameter sets in which all four levels are active, one level is ended by its y dimension before its x dimension, and coordinates sit at 0xFFFE and 0xFFFF. A reference loop model in the bench computes every expected position and flag. The ready line is stalled in a fixed pattern during these runs, and a stray start pulse with altered parameters is injected part way through one walk.

// File: rtl/scan_pkg.sv
package scan_pkg;
   typedef enum logic [1:0] {
      SCAN_IDLE = 2'd0,
      SCAN_RUN  = 2'd1,
      SCAN_DONE = 2'd2
   } scan_state_t;

   localparam int SCAN_MAX_COORD_W = 32;
   localparam int SCAN_MAX_LEVELS  = 8;
endpackage

// File: rtl/scan_axis.sv
module scan_axis #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         adv,
   input  logic         reload,
   input  logic [W-1:0] cfg_start,
   input  logic [W-1:0] cfg_step,
   input  logic [W-1:0] cfg_end,
   output logic [W-1:0] cur,
   output logic         moving,
   output logic         beyond
);
   localparam int EW = W + 2;

   logic [W-1:0]        start_q, step_q, end_q, cur_q;
   logic signed [EW-1:0] nxt, lim;

   // next value without wrap, compared against the end in extended width
   always_comb begin
      nxt    = $signed({2'b00, cur_q}) + $signed({{2{step_q[W-1]}}, step_q});
      lim    = $signed({2'b00, end_q});
      moving = |step_q;
      beyond = step_q[W-1] ? (nxt < lim) : (nxt > lim);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         step_q  <= '0;
         end_q   <= '0;
         cur_q   <= '0;
      end else if (load) begin
         start_q <= cfg_start;
         step_q  <= cfg_step;
         end_q   <= cfg_end;
         cur_q   <= cfg_start;
      end else if (adv) begin
         cur_q <= reload ? start_q : nxt[W-1:0];
      end
   end

   assign cur = cur_q;
endmodule

// File: rtl/scan_level.sv
module scan_level #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         adv,
   input  logic [W-1:0] x_start,
   input  logic [W-1:0] x_step,
   input  logic [W-1:0] x_end,
   input  logic [W-1:0] y_start,
   input  logic [W-1:0] y_step,
   input  logic [W-1:0] y_end,
   output logic [W-1:0] cur_x,
   output logic [W-1:0] cur_y,
   output logic         first,
   output logic         last
);
   logic x_mov, x_out, y_mov, y_out;
   logic first_q;

   scan_axis #(.W(W)) u_ax_x (
      .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .reload(last),
      .cfg_start(x_start), .cfg_step(x_step), .cfg_end(x_end),
      .cur(cur_x), .moving(x_mov), .beyond(x_out)
   );

   scan_axis #(.W(W)) u_ax_y (
      .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .reload(last),
      .cfg_start(y_start), .cfg_step(y_step), .cfg_end(y_end),
      .cur(cur_y), .moving(y_mov), .beyond(y_out)
   );

   // a level with no movement runs once; otherwise either dimension may end it
   assign last = (!x_mov && !y_mov) || (x_mov && x_out) || (y_mov && y_out);

   always_ff @(posedge clk) begin
      if (!rst_n)      first_q <= 1'b0;
      else if (load)   first_q <= 1'b1;
      else if (adv)    first_q <= last;
   end

   assign first = first_q;
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
   import scan_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic finish,
   output logic load,
   output logic running,
   output logic finished
);
   scan_state_t state_q, state_d;

   assign load = start && (state_q != SCAN_RUN);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SCAN_IDLE: if (start)  state_d = SCAN_RUN;
         SCAN_RUN:  if (finish) state_d = SCAN_DONE;
         SCAN_DONE: if (start)  state_d = SCAN_RUN;
         default:               state_d = SCAN_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= SCAN_IDLE;
      else        state_q <= state_d;
   end

   assign running  = (state_q == SCAN_RUN);
   assign finished = (state_q == SCAN_DONE);
endmodule

// File: rtl/scan_pattern_gen.sv
module scan_pattern_gen
   import scan_pkg::*;
#(
   parameter int COORD_W = 16,
   parameter int LEVELS  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [LEVELS*COORD_W-1:0]   cfg_x_start,
   input  logic [LEVELS*COORD_W-1:0]   cfg_x_step,
   input  logic [LEVELS*COORD_W-1:0]   cfg_x_end,
   input  logic [LEVELS*COORD_W-1:0]   cfg_y_start,
   input  logic [LEVELS*COORD_W-1:0]   cfg_y_step,
   input  logic [LEVELS*COORD_W-1:0]   cfg_y_end,
   input  logic                        pos_ready,
   output logic                        pos_valid,
   output logic [COORD_W-1:0]          pos_x,
   output logic [COORD_W-1:0]          pos_y,
   output logic [LEVELS-1:0]           pos_first,
   output logic [LEVELS-1:0]           pos_last,
   output logic                        done
);
   localparam int NCARRY = LEVELS + 1;

   if (COORD_W < 2 || COORD_W > SCAN_MAX_COORD_W) begin : g_bad_width
      $error("scan_pattern_gen: COORD_W out of range");
   end
   if (LEVELS < 1 || LEVELS > SCAN_MAX_LEVELS) begin : g_bad_levels
      $error("scan_pattern_gen: LEVELS out of range");
   end

   logic               load, running, fire;
   logic [NCARRY-1:0]  carry;
   logic [COORD_W-1:0] lvl_x [LEVELS];
   logic [COORD_W-1:0] lvl_y [LEVELS];

   assign fire     = running && pos_ready;
   assign carry[0] = fire;

   scan_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .finish(carry[LEVELS]),
      .load(load), .running(running), .finished(done)
   );

   for (genvar l = 0; l < LEVELS; l++) begin : g_level
      scan_level #(.W(COORD_W)) u_lvl (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (load),
         .adv     (carry[l]),
         .x_start (cfg_x_start[l*COORD_W +: COORD_W]),
         .x_step  (cfg_x_step [l*COORD_W +: COORD_W]),
         .x_end   (cfg_x_end  [l*COORD_W +: COORD_W]),
         .y_start (cfg_y_start[l*COORD_W +: COORD_W]),
         .y_step  (cfg_y_step [l*COORD_W +: COORD_W]),
         .y_end   (cfg_y_end  [l*COORD_W +: COORD_W]),
         .cur_x   (lvl_x[l]),
         .cur_y   (lvl_y[l]),
         .first   (pos_first[l]),
         .last    (pos_last[l])
      );
      // the step ripples outward only past levels sitting in their last pass
      assign carry[l+1] = carry[l] && pos_last[l];
   end

   if (LEVELS == 1) begin : g_sum_single
      assign pos_x = lvl_x[0];
      assign pos_y = lvl_y[0];
   end else begin : g_sum_tree
      always_comb begin
         pos_x = '0;
         pos_y = '0;
         for (int l = 0; l < LEVELS; l++) begin
            pos_x = pos_x + lvl_x[l];
            pos_y = pos_y + lvl_y[l];
         end
      end
   end

   assign pos_valid = running;
endmodule

// File: rtl/scan_pattern_gen_chk.sv
module scan_pattern_gen_chk #(
   parameter int COORD_W = 16,
   parameter int LEVELS  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               pos_ready,
   input logic               pos_valid,
   input logic [COORD_W-1:0] pos_x,
   input logic [COORD_W-1:0] pos_y,
   input logic [LEVELS-1:0]  pos_first,
   input logic [LEVELS-1:0]  pos_last,
   input logic               done
);
   assert_valid_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(pos_valid && done));

   assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !pos_valid) |=> (pos_valid && (&pos_first)));

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_valid && !pos_ready) |=> (pos_valid && $stable(pos_x) && $stable(pos_y)
                                     && $stable(pos_first) && $stable(pos_last)));

   assert_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_valid && pos_ready && (&pos_last)) |=> (done && !pos_valid));

   assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   assert_run_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_valid && start && !(pos_ready && (&pos_last))) |=> pos_valid);

   assert_inner_step_clears_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_valid && pos_ready && !pos_last[0]) |=> !pos_first[0]);

   assert_inner_reload_sets_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_valid && pos_ready && pos_last[0] && !(&pos_last)) |=> (pos_valid && pos_first[0]));
endmodule

bind scan_pattern_gen scan_pattern_gen_chk #(.COORD_W(COORD_W), .LEVELS(LEVELS)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .pos_ready(pos_ready),
   .pos_valid(pos_valid), .pos_x(pos_x), .pos_y(pos_y),
   .pos_first(pos_first), .pos_last(pos_last), .done(done)
);

// File: tb/scan_pattern_gen_tb.sv
module scan_pattern_gen_tb;
   localparam int W = 16;
   localparam int L = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [L*W-1:0] cfg_x_start, cfg_x_step, cfg_x_end;
   logic [L*W-1:0] cfg_y_start, cfg_y_step, cfg_y_end;
   logic           pos_ready = 1'b0;
   logic           pos_valid;
   logic [W-1:0]   pos_x, pos_y;
   logic [L-1:0]   pos_first, pos_last;
   logic           done;

   int checks = 0;
   int errors = 0;

   // reference parameter copies and loop state
   int cxs[L], cxi[L], cxe[L], cys[L], cyi[L], cye[L];
   int mx[L], my[L];
   bit mfirst[L];

   always #10 clk = ~clk;

   scan_pattern_gen #(.COORD_W(W), .LEVELS(L)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_x_start(cfg_x_start), .cfg_x_step(cfg_x_step), .cfg_x_end(cfg_x_end),
      .cfg_y_start(cfg_y_start), .cfg_y_step(cfg_y_step), .cfg_y_end(cfg_y_end),
      .pos_ready(pos_ready), .pos_valid(pos_valid), .pos_x(pos_x), .pos_y(pos_y),
      .pos_first(pos_first), .pos_last(pos_last), .done(done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic set_level(input int l, input int xs, input int xi, input int xe,
                            input int ys, input int yi, input int ye);
      cxs[l] = xs; cxi[l] = xi; cxe[l] = xe;
      cys[l] = ys; cyi[l] = yi; cye[l] = ye;
   endtask

   task automatic drive_cfg();
      for (int l = 0; l < L; l++) begin
         cfg_x_start[l*W +: W] = cxs[l][W-1:0];
         cfg_x_step [l*W +: W] = cxi[l][W-1:0];
         cfg_x_end  [l*W +: W] = cxe[l][W-1:0];
         cfg_y_start[l*W +: W] = cys[l][W-1:0];
         cfg_y_step [l*W +: W] = cyi[l][W-1:0];
         cfg_y_end  [l*W +: W] = cye[l][W-1:0];
      end
   endtask

   // R4 termination rule
   function automatic bit passes(input int cur, input int stp, input int lim);
      int n = cur + stp;
      if (stp > 0) return n > lim;
      if (stp < 0) return n < lim;
      return 1'b0;
   endfunction

   function automatic bit lvl_last(input int l);
      if (cxi[l] == 0 && cyi[l] == 0) return 1'b1;
      return (cxi[l] != 0 && passes(mx[l], cxi[l], cxe[l])) ||
             (cyi[l] != 0 && passes(my[l], cyi[l], cye[l]));
   endfunction

   // R5 nesting: lowest non-last level steps, lower levels reload
   function automatic bit model_step();
      for (int l = 0; l < L; l++) begin
         if (!lvl_last(l)) begin
            mx[l] = mx[l] + cxi[l];
            my[l] = my[l] + cyi[l];
            mfirst[l] = 1'b0;
            return 1'b0;
         end
         mx[l] = cxs[l]; my[l] = cys[l]; mfirst[l] = 1'b1;
      end
      return 1'b1;
   endfunction

   task automatic run_walk(input string name, input int stall_mode, input int exp_count,
                           input bit inject_start);
      int count = 0;
      int cyc = 0;
      bit fin = 0;
      logic [W-1:0] hx = '0, hy = '0;
      bit was_stall = 0;
      drive_cfg();
      for (int l = 0; l < L; l++) begin
         mx[l] = cxs[l]; my[l] = cys[l]; mfirst[l] = 1'b1;
      end
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!fin && cyc < 2000) begin
         int ex = 0, ey = 0;
         logic [L-1:0] ef, el;
         for (int l = 0; l < L; l++) begin
            ex += mx[l]; ey += my[l];
            ef[l] = mfirst[l]; el[l] = lvl_last(l);
         end
         start = 1'b0;
         if (!pos_valid) begin
            check(0, "R5", {name, " valid dropped early"}, count, exp_count);
            fin = 1;
         end else begin
            check(pos_x == ex[W-1:0] && pos_y == ey[W-1:0], "R3",
                  {name, " position"}, {pos_x, pos_y}, {ex[W-1:0], ey[W-1:0]});
            check(pos_first == ef && pos_last == el, "R6 R7",
                  {name, " flags first/last"}, {pos_first, pos_last}, {ef, el});
            if (was_stall)
               check(pos_x == hx && pos_y == hy, "R8", {name, " stall hold"},
                     {pos_x, pos_y}, {hx, hy});
            hx = pos_x; hy = pos_y;
            pos_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            was_stall = !pos_ready;
            if (inject_start && count == 2) begin
               // R10: stray start and altered parameters during the run
               start = 1'b1;
               cfg_x_start = ~cfg_x_start;
               cfg_y_step  = '0;
               cfg_x_end   = '0;
            end
            if (pos_ready) begin
               count++;
               fin = model_step();
            end
            @(negedge clk);
            cyc++;
         end
      end
      start = 1'b0;
      pos_ready = 1'b0;
      check(count == exp_count, "R4", {name, " position count"}, count, exp_count);
      check(done && !pos_valid, "R9", {name, " done after last"}, {done, pos_valid}, 2'b10);
      repeat (3) @(negedge clk);
      check(done && !pos_valid, "R9", {name, " done held"}, {done, pos_valid}, 2'b10);
   endtask

   task automatic t_reset();
      check(!pos_valid && !done, "R1", "reset state", {pos_valid, done}, 2'b00);
      repeat (3) @(negedge clk);
      check(!pos_valid && !done, "R1", "idle without start", {pos_valid, done}, 2'b00);
   endtask

   task automatic t_video();
      set_level(0, 0, 1, 3, 0, 0, 0);
      set_level(1, 0, 0, 0, 0, 1, 2);
      set_level(2, 0, 0, 0, 0, 0, 0);
      set_level(3, 0, 0, 0, 0, 0, 0);
      run_walk("video R2", 0, 12, 0);
   endtask

   task automatic t_countdown();
      set_level(0, 10, -3, 4, 0, 0, 0);
      set_level(1, 100, 0, 0, 50, -5, 40);
      set_level(2, 0, 0, 0, 0, 0, 0);
      set_level(3, 1000, 500, 2000, 7, 1, 8);
      run_walk("countdown stalls", 1, 18, 0);
   endtask

   task automatic t_edges();
      set_level(0, 16'hFFFE, 1, 16'hFFFF, 0, 0, 0);
      set_level(1, 16'hFFFF, 1, 16'hFFFF, 0, 0, 0);
      set_level(2, 0, 1, 5, 3, 2, 3);
      set_level(3, 2, -1, 0, 0, 0, 0);
      run_walk("range edges", 1, 6, 0);
   endtask

   task automatic t_restart_ignore();
      set_level(0, 0, 1, 3, 0, 0, 0);
      set_level(1, 0, 0, 0, 0, 1, 2);
      set_level(2, 0, 0, 0, 0, 0, 0);
      set_level(3, 0, 0, 0, 0, 0, 0);
      run_walk("restart R10", 1, 12, 1);
   endtask

   initial begin
      cfg_x_start = '0; cfg_x_step = '0; cfg_x_end = '0;
      cfg_y_start = '0; cfg_y_step = '0; cfg_y_end = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_video();
      t_countdown();
      t_edges();
      t_restart_ignore();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule